// File: doc/BRIEF.md
# Three-Phase Gate Control with Dead-Time Insertion

This block turns six PWM request lines into six gate enables for a three-phase half-bridge power stage, one high-side and one low-side enable per phase (A, B, C). A two-bit mode field picks how the PWM lines are read. In six-input mode each line drives one transistor. In three-input mode each phase has a level line and an enable line. In one-input mode a single PWM line is steered by a three-bit Hall state through a fixed commutation table. In independent mode every line passes straight through.

In all modes except independent, a programmable dead time keeps both transistors of a half-bridge off for a fixed number of system clocks before either one turns on. Turn-off always takes effect at the next clock edge. Global overrides sit above the mode logic. A fault force-off turns every transistor off. The brake turns every low side on, in one-input mode only. Coast turns every transistor off. A Hi-Z indication reports when the stage has been released by the fault or coast override.

Mode and dead-time codes are captured into internal configuration registers on a load strobe. The dead time is counted in clocks derived from a clock-period parameter, rounded up.

Top module: `pwm_gate_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, with no inputs active, all six gate enables and `hiz_o` are 0. Without a configuration load, the block runs in six-input mode with a 100 ns dead time.
- R2: The dead-time codes are 00=50 ns, 01=100 ns, 10=200 ns and 11=400 ns. In every mode but independent, once a phase's active side turns off, both sides of that phase stay off for exactly ceil(ns / CLK_PERIOD_NS) clocks before the other side turns on. A side also turns on only after both sides have been off for that time.
- R3: In six-input mode (mode 00), `pwm_i[2p+1]` requests phase p's high side and `pwm_i[2p]` requests its low side. Phase 0 is A, 1 is B and 2 is C. If both sides are requested at once, neither is enabled.
- R4: In three-input mode (mode 01), `pwm_i[2p+1]` is phase p's level and `pwm_i[2p]` is its enable. When the enable is 1, the level drives the high side and its complement drives the low side. When the enable is 0, both sides are off.
- R5: In independent mode (mode 11), each gate enable equals its PWM line one clock later. No dead time is applied, and both sides of a phase may be on.
- R6: In one-input mode (mode 10), `pwm_i[1]` is the PWM and the Hall state is {`pwm_i[3]`, `pwm_i[2]`, `pwm_i[0]`}. The Hall state maps to a (sourcing phase, sinking phase) pair as follows: 001→(A,B), 011→(A,C), 010→(B,C), 110→(B,A), 100→(C,A), 101→(C,B). Hall states 000 and 111 turn all gates off. The sourcing phase's high side follows the PWM, the sinking phase's low side is on, and the third phase is off.
- R7: In one-input mode, the direction is `dir_i` OR `pwm_i[5]`. A direction of 1 swaps the sourcing and sinking phases.
- R8: In one-input mode, with `freewheel_i`=0 the sourcing phase's low side is on while the PWM is low. With `freewheel_i`=1 that low side stays off.
- R9: In one-input mode, the brake is `brake_i` OR `pwm_i[4]`. An active brake turns all high sides off and all three low sides on. In other modes `brake_i` has no effect.
- R10: Coast (`coast_i`=1) turns all six gates off at the next clock and sets `hiz_o`. An active brake takes precedence over coast and clears `hiz_o`.
- R11: Fault force-off (`fault_off_i`=1) turns all six gates off at the next clock and sets `hiz_o`, overriding brake, coast and PWM.
- R12: Outside independent mode, the high and low enables of a phase are never 1 together.
- R13: `mode_i` and `dt_code_i` take effect only on a clock where `cfg_load_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Captures mode_i and dt_code_i |
| mode_i | input | 2 | PWM mode code |
| dt_code_i | input | 2 | Dead-time code |
| pwm_i | input | 6 | PWM lines, bit 2p+1 high / bit 2p low of phase p |
| dir_i | input | 1 | Direction bit for one-input mode |
| freewheel_i | input | 1 | 1 = diode freewheel, 0 = synchronous low side |
| coast_i | input | 1 | Release all transistors |
| brake_i | input | 1 | Brake bit for one-input mode |
| fault_off_i | input | 1 | Force-off request from fault logic |
| gate_hi_o | output | 3 | High-side enables, bit p = phase p |
| gate_lo_o | output | 3 | Low-side enables, bit p = phase p |
| hiz_o | output | 1 | Stage released by fault or coast |

## Verification
The dead time is measured as a count of clocks from a high-to-low swap on phase A. This is done for every code, including the reset default. The count separates correct rounding from off-by-one errors and wrong code decoding.

Six-input mode is tried with single requests and with conflicting requests. Three-input mode uses a mixed pattern with one phase enabled high, one enabled low and one disabled, which tells the level line apart from the enable line. Independent mode is tested with all lines high, which checks both the absence of the dead-time gate and the one-clock latency.

One-input mode walks several Hall states with both direction sources, both rectification settings and an invalid Hall code. The overrides are applied in combination (brake with coast, fault with brake, brake outside one-input mode) to check their priority. A burst of changing PWM patterns in six-input mode looks for any cycle with overlapping enables.

// File: rtl/gate_ctrl_pkg.sv
package gate_ctrl_pkg;
  localparam int NPH = 3;

  typedef enum logic [1:0] {
    MODE_SIX   = 2'b00,
    MODE_THREE = 2'b01,
    MODE_ONE   = 2'b10,
    MODE_INDEP = 2'b11
  } pwm_mode_e;

  localparam logic [1:0] DT_RESET_CODE = 2'b01;

  function automatic int dt_ns(input int code);
    case (code)
      0:       return 50;
      1:       return 100;
      2:       return 200;
      default: return 400;
    endcase
  endfunction

  // round up to whole clocks
  function automatic int dt_cycles(input int code, input int period_ns);
    return (dt_ns(code) + period_ns - 1) / period_ns;
  endfunction
endpackage

// File: rtl/gate_commutate.sv
module gate_commutate
  import gate_ctrl_pkg::*;
(
  input  logic [2:0]     hall_i,
  input  logic           pwm_i,
  input  logic           dir_i,
  input  logic           freewheel_i,
  output logic [NPH-1:0] hi_o,
  output logic [NPH-1:0] lo_o
);
  logic [1:0] src, snk, a, b;
  logic       valid;

  always_comb begin
    valid = 1'b1;
    a     = 2'd0;
    b     = 2'd1;
    case (hall_i)
      3'b001: begin a = 2'd0; b = 2'd1; end
      3'b011: begin a = 2'd0; b = 2'd2; end
      3'b010: begin a = 2'd1; b = 2'd2; end
      3'b110: begin a = 2'd1; b = 2'd0; end
      3'b100: begin a = 2'd2; b = 2'd0; end
      3'b101: begin a = 2'd2; b = 2'd1; end
      default: valid = 1'b0;
    endcase
    src = dir_i ? b : a;
    snk = dir_i ? a : b;
    for (int p = 0; p < NPH; p++) begin
      hi_o[p] = valid && (src == 2'(p)) && pwm_i;
      lo_o[p] = valid && ((snk == 2'(p)) ||
                          ((src == 2'(p)) && !pwm_i && !freewheel_i));
    end
  end
endmodule

// File: rtl/gate_req_mux.sv
module gate_req_mux
  import gate_ctrl_pkg::*;
(
  input  pwm_mode_e        mode_i,
  input  logic [2*NPH-1:0] pwm_i,
  input  logic             dir_i,
  input  logic             freewheel_i,
  input  logic             coast_i,
  input  logic             brake_i,
  input  logic             fault_off_i,
  output logic [NPH-1:0]   req_hi_o,
  output logic [NPH-1:0]   req_lo_o,
  output logic             hiz_req_o
);
  logic [NPH-1:0] one_hi, one_lo;
  logic           brake_act;

  gate_commutate u_comm (
    .hall_i      ({pwm_i[3], pwm_i[2], pwm_i[0]}),
    .pwm_i       (pwm_i[1]),
    .dir_i       (dir_i | pwm_i[5]),
    .freewheel_i (freewheel_i),
    .hi_o        (one_hi),
    .lo_o        (one_lo)
  );

  assign brake_act = (mode_i == MODE_ONE) && (brake_i || pwm_i[4]);

  always_comb begin
    for (int p = 0; p < NPH; p++) begin
      case (mode_i)
        MODE_SIX: begin
          req_hi_o[p] = pwm_i[2*p+1] & ~pwm_i[2*p];
          req_lo_o[p] = pwm_i[2*p]   & ~pwm_i[2*p+1];
        end
        MODE_THREE: begin
          req_hi_o[p] = pwm_i[2*p] &  pwm_i[2*p+1];
          req_lo_o[p] = pwm_i[2*p] & ~pwm_i[2*p+1];
        end
        MODE_ONE: begin
          req_hi_o[p] = one_hi[p];
          req_lo_o[p] = one_lo[p];
        end
        default: begin
          req_hi_o[p] = pwm_i[2*p+1];
          req_lo_o[p] = pwm_i[2*p];
        end
      endcase
    end
    hiz_req_o = 1'b0;
    if (fault_off_i) begin
      req_hi_o  = '0;
      req_lo_o  = '0;
      hiz_req_o = 1'b1;
    end else if (brake_act) begin
      req_hi_o = '0;
      req_lo_o = '1;
    end else if (coast_i) begin
      req_hi_o  = '0;
      req_lo_o  = '0;
      hiz_req_o = 1'b1;
    end
  end
endmodule

// File: rtl/gate_deadband.sv
module gate_deadband #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_hi_i,
  input  logic             req_lo_i,
  input  logic             bypass_i,
  input  logic [CNT_W-1:0] dt_cyc_i,
  output logic             gate_hi_o,
  output logic             gate_lo_o
);
  logic [CNT_W-1:0] off_cnt;
  logic             ready, hi_n, lo_n;

  // off_cnt = clocks both sides have been off, saturating
  assign ready = off_cnt >= dt_cyc_i;

  always_comb begin
    if (bypass_i) begin
      hi_n = req_hi_i;
      lo_n = req_lo_i;
    end else begin
      hi_n = req_hi_i & (gate_hi_o | (~gate_lo_o & ready));
      lo_n = req_lo_i & (gate_lo_o | (~gate_hi_o & ready));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_hi_o <= 1'b0;
      gate_lo_o <= 1'b0;
      off_cnt   <= '0;
    end else begin
      gate_hi_o <= hi_n;
      gate_lo_o <= lo_n;
      if (gate_hi_o || gate_lo_o) off_cnt <= CNT_W'(1);
      else if (off_cnt != '1)     off_cnt <= off_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pwm_gate_ctrl.sv
module pwm_gate_ctrl
  import gate_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_load_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       dt_code_i,
  input  logic [2*NPH-1:0] pwm_i,
  input  logic             dir_i,
  input  logic             freewheel_i,
  input  logic             coast_i,
  input  logic             brake_i,
  input  logic             fault_off_i,
  output logic [NPH-1:0]   gate_hi_o,
  output logic [NPH-1:0]   gate_lo_o,
  output logic             hiz_o
);
  localparam int DT_C0  = dt_cycles(0, CLK_PERIOD_NS);
  localparam int DT_C1  = dt_cycles(1, CLK_PERIOD_NS);
  localparam int DT_C2  = dt_cycles(2, CLK_PERIOD_NS);
  localparam int DT_C3  = dt_cycles(3, CLK_PERIOD_NS);
  localparam int CNT_W  = $clog2(DT_C3 + 1) + 1;

  pwm_mode_e        mode_q;
  logic [1:0]       dt_q;
  logic [CNT_W-1:0] dt_cyc;
  logic [NPH-1:0]   req_hi, req_lo;
  logic             hiz_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SIX;
      dt_q   <= DT_RESET_CODE;
      hiz_o  <= 1'b0;
    end else begin
      if (cfg_load_i) begin
        mode_q <= pwm_mode_e'(mode_i);
        dt_q   <= dt_code_i;
      end
      hiz_o <= hiz_req;
    end
  end

  always_comb begin
    case (dt_q)
      2'd0:    dt_cyc = CNT_W'(DT_C0);
      2'd1:    dt_cyc = CNT_W'(DT_C1);
      2'd2:    dt_cyc = CNT_W'(DT_C2);
      default: dt_cyc = CNT_W'(DT_C3);
    endcase
  end

  gate_req_mux u_mux (
    .mode_i      (mode_q),
    .pwm_i       (pwm_i),
    .dir_i       (dir_i),
    .freewheel_i (freewheel_i),
    .coast_i     (coast_i),
    .brake_i     (brake_i),
    .fault_off_i (fault_off_i),
    .req_hi_o    (req_hi),
    .req_lo_o    (req_lo),
    .hiz_req_o   (hiz_req)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    gate_deadband #(.CNT_W(CNT_W)) u_db (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_hi_i  (req_hi[p]),
      .req_lo_i  (req_lo[p]),
      .bypass_i  (mode_q == MODE_INDEP),
      .dt_cyc_i  (dt_cyc),
      .gate_hi_o (gate_hi_o[p]),
      .gate_lo_o (gate_lo_o[p])
    );
  end
endmodule

// File: rtl/gate_ctrl_chk.sv
module gate_ctrl_chk
  import gate_ctrl_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic [1:0]     mode_q,
  input logic [5:0]     pwm_i,
  input logic           coast_i,
  input logic           brake_i,
  input logic           fault_off_i,
  input logic [NPH-1:0] gate_hi_o,
  input logic [NPH-1:0] gate_lo_o,
  input logic           hiz_o
);
  for (genvar p = 0; p < NPH; p++) begin : g_chk
    p_no_overlap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(mode_q) != MODE_INDEP) |-> !(gate_hi_o[p] && gate_lo_o[p]));
    p_lo_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(mode_q) != MODE_INDEP && $rose(gate_lo_o[p])) |-> !$past(gate_hi_o[p]));
    p_hi_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(mode_q) != MODE_INDEP && $rose(gate_hi_o[p])) |-> !$past(gate_lo_o[p]));
  end

  p_fault_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_off_i |=> (gate_hi_o == '0 && gate_lo_o == '0 && hiz_o));

  p_coast_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coast_i && mode_q != MODE_ONE) |=> (gate_hi_o == '0 && gate_lo_o == '0 && hiz_o));

  p_brake_hi_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_ONE && (brake_i || pwm_i[4]) && !fault_off_i)
      |=> (gate_hi_o == '0 && !hiz_o));
endmodule

bind pwm_gate_ctrl gate_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_q      (mode_q),
  .pwm_i       (pwm_i),
  .coast_i     (coast_i),
  .brake_i     (brake_i),
  .fault_off_i (fault_off_i),
  .gate_hi_o   (gate_hi_o),
  .gate_lo_o   (gate_lo_o),
  .hiz_o       (hiz_o)
);

// File: tb/tb_pwm_gate_ctrl.sv
module tb_pwm_gate_ctrl;
  localparam int PER = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_load_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [1:0] dt_code_i = 2'b00;
  logic [5:0] pwm_i = '0;
  logic       dir_i = 1'b0, freewheel_i = 1'b0, coast_i = 1'b0;
  logic       brake_i = 1'b0, fault_off_i = 1'b0;
  logic [2:0] gate_hi_o, gate_lo_o;
  logic       hiz_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_gate_ctrl #(.CLK_PERIOD_NS(PER)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_load_i(cfg_load_i), .mode_i(mode_i),
    .dt_code_i(dt_code_i), .pwm_i(pwm_i), .dir_i(dir_i), .freewheel_i(freewheel_i),
    .coast_i(coast_i), .brake_i(brake_i), .fault_off_i(fault_off_i),
    .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o), .hiz_o(hiz_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {hiz, hi[2:0], lo[2:0]}
  function automatic int outs();
    return int'({hiz_o, gate_hi_o, gate_lo_o});
  endfunction

  task automatic load_cfg(input logic [1:0] m, input logic [1:0] c);
    mode_i = m; dt_code_i = c; cfg_load_i = 1'b1;
    step(1);
    cfg_load_i = 1'b0;
  endtask

  task automatic measure_dt(input string tag, input int ns);
    int exp_cyc;
    int n;
    exp_cyc = (ns + PER - 1) / PER;
    pwm_i = 6'b000010;
    step(120);
    chk({tag, " hi on"}, outs(), 7'b0_001_000);
    pwm_i = 6'b000001;
    step(1);
    chk({tag, " hi off next clock"}, int'(gate_hi_o[0]), 0);
    n = 1;
    for (int k = 0; k < 200 && !gate_lo_o[0]; k++) begin
      step(1);
      n++;
    end
    chk({tag, " dead-time clocks"}, n, exp_cyc + 1);
  endtask

  task automatic t_reset;
    step(3);
    chk("R1 outputs in reset", outs(), 0);
    rst_ni = 1'b1;
    step(5);
    chk("R1 outputs after reset", outs(), 0);
    measure_dt("R1 default 6-input 100ns", 100);
  endtask

  task automatic t_dead_codes;
    load_cfg(2'b00, 2'b00); measure_dt("R2 code00", 50);
    load_cfg(2'b00, 2'b10); measure_dt("R2 code10", 200);
    load_cfg(2'b00, 2'b11); measure_dt("R2 code11", 400);
    load_cfg(2'b00, 2'b00);
  endtask

  task automatic t_six;
    pwm_i = 6'b001000; step(20);
    chk("R3 B high only", outs(), 7'b0_010_000);
    pwm_i = 6'b001100; step(20);
    chk("R3 B both requested", outs(), 0);
    pwm_i = 6'b010000; step(20);
    chk("R3 C low only", outs(), 7'b0_000_100);
    // R13: mode code changes without load are ignored
    mode_i = 2'b11; step(5);
    pwm_i = 6'b000011; step(20);
    chk("R13 mode held without load", outs(), 0);
  endtask

  task automatic t_three;
    load_cfg(2'b01, 2'b00);
    pwm_i = 6'b10_01_11; step(20);
    chk("R4 mixed en/level", outs(), 7'b0_001_010);
  endtask

  task automatic t_indep;
    load_cfg(2'b11, 2'b00);
    pwm_i = 6'b000000; step(3);
    pwm_i = 6'b111111; step(1);
    chk("R5 all on one clock", outs(), 7'b0_111_111);
    pwm_i = 6'b000000; step(3);
  endtask

  task automatic t_one;
    load_cfg(2'b10, 2'b00);
    pwm_i = 6'b000011; step(20);
    chk("R6 hall001 pwm high", outs(), 7'b0_001_010);
    pwm_i = 6'b000001; step(20);
    chk("R8 sync low side", outs(), 7'b0_000_011);
    freewheel_i = 1'b1; step(20);
    chk("R8 freewheel", outs(), 7'b0_000_010);
    freewheel_i = 1'b0;
    pwm_i = 6'b000110; step(20);
    chk("R6 hall010", outs(), 7'b0_010_100);
    dir_i = 1'b1; step(20);
    chk("R7 dir bit reverses", outs(), 7'b0_100_010);
    dir_i = 1'b0; pwm_i = 6'b100110; step(20);
    chk("R7 dir pin reverses", outs(), 7'b0_100_010);
    pwm_i = 6'b000000; step(20);
    chk("R6 invalid hall off", outs(), 0);
  endtask

  task automatic t_overrides;
    pwm_i = 6'b000011; step(20);
    brake_i = 1'b1; step(20);
    chk("R9 brake bit lows on", outs(), 7'b0_000_111);
    coast_i = 1'b1; step(5);
    chk("R10 brake over coast", outs(), 7'b0_000_111);
    fault_off_i = 1'b1; step(1);
    chk("R11 fault over brake", outs(), 7'b1_000_000);
    fault_off_i = 1'b0; brake_i = 1'b0; step(1);
    chk("R10 coast releases", outs(), 7'b1_000_000);
    coast_i = 1'b0; pwm_i = 6'b010011; step(20);
    chk("R9 brake pin lows on", outs(), 7'b0_000_111);
    pwm_i = 6'b000011; step(20);
    load_cfg(2'b00, 2'b00);
    pwm_i = 6'b000010; step(20);
    brake_i = 1'b1; step(20);
    chk("R9 brake ignored in 6-input", outs(), 7'b0_001_000);
    brake_i = 1'b0;
    coast_i = 1'b1; step(1);
    chk("R10 coast all off", outs(), 7'b1_000_000);
    coast_i = 1'b0; step(20);
    chk("R10 resume after coast", outs(), 7'b0_001_000);
  endtask

  task automatic t_overlap;
    int bad = 0;
    logic [5:0] v = 6'b101101;
    for (int k = 0; k < 400; k++) begin
      if (k % 3 == 0) v = {v[4:0], v[5] ^ v[2]};
      pwm_i = v;
      step(1);
      if ((gate_hi_o & gate_lo_o) != 3'b000) bad++;
    end
    chk("R12 overlap cycles", bad, 0);
  endtask

  initial begin
    t_reset();
    t_dead_codes();
    t_six();
    t_three();
    t_indep();
    t_one();
    t_overrides();
    t_overlap();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule